// File: doc/BRIEF.md
# Burst-of-Four Split-Port Memory Datapath

This block is a synchronous memory core with one address bus, a write data bus and a separate read data bus. Address and command are sampled once per clock, and each access moves four data words (beats), one beat per clock. On the write side a collector gathers the four incoming beats into one array word, four times the bus width, and stores that word in a single array write on the edge that samples the last beat. On the read side the whole array word is fetched at once and sent out as four consecutive beats after a fixed latency, with a valid flag.

Each address selects a group of four words, so the address bus is two bits narrower than a word-granular address would be. At most one command is taken per cycle. A burst occupies its own data bus for four cycles. A command of the same direction that arrives while that bus is still busy is dropped. A cycle carrying both a read and a write is an error: the read is kept, the write is discarded and an error flag is raised.

Top module: `bmem_b4_core`

## Requirements
- R1: After reset, and until the first read is taken, rd_valid and conflict_err are low and rd_data is all zeros.
- R2: A write is taken on the edge where wr_req is high, rd_req is low and no write burst is open. That edge samples addr and beat 0 from wr_data, and the next three edges sample beats 1, 2 and 3. The group is stored as one array word on the edge that samples beat 3.
- R3: A read is taken on an edge where rd_req is high and no read burst is open. Beat 0 of the addressed group is on rd_data after the third following edge (READ_LAT = 3). Beats 1, 2 and 3 follow on the next three edges. Beat k read equals beat k written.
- R4: rd_valid is high in exactly the four cycles that carry the beats of each taken read and low in every other cycle. Reads taken four cycles apart give an unbroken run of valid beats.
- R5: Whenever rd_valid is low, rd_data is all zeros.
- R6: Each of the 2^ADDR_W address values selects its own group of four words, including address 0 and the all-ones address.
- R7: A read of a group whose write burst is still open returns the previous contents. This holds up to and including the read taken on the edge that samples beat 3.
- R8: When rd_req and wr_req are both high on an edge, conflict_err is high for the following cycle and low after any edge without both. The read is performed and the write is discarded, so the group keeps its previous contents.
- R9: A wr_req raised while a write burst is open is ignored, and the group at the address presented with it is left unchanged.
- R10: A rd_req raised in the three cycles after a taken read is ignored and produces no extra beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Read command for the group at addr |
| wr_req | input | 1 | Write command for the group at addr; beat 0 on wr_data in the same cycle |
| addr | input | ADDR_W | Group address, one group of four words per value |
| wr_data | input | DATA_W | Write beat bus |
| rd_data | output | DATA_W | Read beat bus; zero outside a burst |
| rd_valid | output | 1 | High while rd_data carries a read beat |
| conflict_err | output | 1 | High the cycle after rd_req and wr_req were both high |

## Verification
The hardest case to reach is a read that lands inside the four-cycle window of an open write to the same group. The hardest of those is the read taken on the very edge that commits the word, where array write and array read coincide. The stimulus forks a write burst and a read task offset by one and by three cycles on the shared address bus. It then reads the group again after the commit to show the new word arrived. Dropped commands are driven in the middle of open bursts. Their effect is observed at the ports, either as a group that kept its old contents or as the absence of extra valid beats.

// File: rtl/bmem_pkg.sv
package bmem_pkg;
   localparam int BEATS  = 4;
   localparam int BEAT_W = $clog2(BEATS);

   typedef logic [BEAT_W-1:0] beat_idx_t;

   localparam beat_idx_t LAST_BEAT = beat_idx_t'(BEATS - 1);
   localparam beat_idx_t ONE_BEAT  = beat_idx_t'(1);
endpackage

// File: rtl/bmem_cmd_ctrl.sv
module bmem_cmd_ctrl
   import bmem_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rd_req,
   input  logic wr_req,
   input  logic wr_busy,
   output logic rd_issue,
   output logic wr_issue,
   output logic conflict_err
);
   beat_idx_t rd_gap_q;
   logic      rd_open;
   logic      both_req;

   assign rd_open  = (rd_gap_q != '0);
   assign both_req = rd_req && wr_req;
   assign rd_issue = rd_req && !rd_open;
   assign wr_issue = wr_req && !rd_req && !wr_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_gap_q     <= '0;
         conflict_err <= 1'b0;
      end else begin
         conflict_err <= both_req;
         if (rd_issue) begin
            rd_gap_q <= LAST_BEAT;
         end else if (rd_open) begin
            rd_gap_q <= rd_gap_q - ONE_BEAT;
         end
      end
   end
endmodule

// File: rtl/bmem_wr_collect.sv
module bmem_wr_collect
   import bmem_pkg::*;
#(
   parameter  int DATA_W = 18,
   parameter  int ADDR_W = 6,
   localparam int WORD_W = DATA_W * BEATS
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] beat_in,
   output logic              busy,
   output logic              commit,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [WORD_W-1:0] commit_word
);
   localparam int HELD_W = DATA_W * (BEATS - 1);

   logic              busy_q;
   beat_idx_t         idx_q;
   logic [ADDR_W-1:0] addr_q;
   logic [HELD_W-1:0] held_beats;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         addr_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         idx_q  <= ONE_BEAT;
         addr_q <= addr_in;
      end else if (busy_q) begin
         if (idx_q == LAST_BEAT) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + ONE_BEAT;
         end
      end
   end

   for (genvar g = 0; g < BEATS - 1; g++) begin : g_lane
      logic              take;
      logic [DATA_W-1:0] lane_q;

      if (g == 0) begin : g_first
         assign take = start;
      end else begin : g_later
         assign take = busy_q && (idx_q == beat_idx_t'(g));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (take) begin
            lane_q <= beat_in;
         end
      end

      assign held_beats[g*DATA_W +: DATA_W] = lane_q;
   end

   assign busy        = busy_q;
   assign commit      = busy_q && (idx_q == LAST_BEAT);
   assign commit_addr = addr_q;
   assign commit_word = {beat_in, held_beats};
endmodule

// File: rtl/bmem_array.sv
module bmem_array #(
   parameter  int ADDR_W = 6,
   parameter  int WORD_W = 72,
   localparam int DEPTH  = 1 << ADDR_W
)(
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      if (re) begin
         rdata <= mem[raddr];
      end
   end
endmodule

// File: rtl/bmem_rd_serial.sv
module bmem_rd_serial
   import bmem_pkg::*;
#(
   parameter  int DATA_W   = 18,
   parameter  int READ_LAT = 3,
   localparam int WORD_W   = DATA_W * BEATS
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [WORD_W-1:0] word_in,
   output logic [DATA_W-1:0] beat_out,
   output logic              beat_valid
);
   localparam int REM_W = WORD_W - DATA_W;

   logic              fetched_q;
   logic              load;
   logic [WORD_W-1:0] load_word;
   logic [REM_W-1:0]  rem_q;
   beat_idx_t         left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetched_q <= 1'b0;
      end else begin
         fetched_q <= issue;
      end
   end

   if (READ_LAT == 1) begin : g_direct
      assign load      = fetched_q;
      assign load_word = word_in;
   end else begin : g_chain
      logic [WORD_W-1:0] w_dly [READ_LAT-1];
      logic [READ_LAT-2:0] v_dly;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_dly <= '0;
            for (int i = 0; i < READ_LAT - 1; i++) begin
               w_dly[i] <= '0;
            end
         end else begin
            v_dly[0] <= fetched_q;
            w_dly[0] <= word_in;
            for (int i = 1; i < READ_LAT - 1; i++) begin
               v_dly[i] <= v_dly[i-1];
               w_dly[i] <= w_dly[i-1];
            end
         end
      end

      assign load      = v_dly[READ_LAT-2];
      assign load_word = w_dly[READ_LAT-2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_out   <= '0;
         beat_valid <= 1'b0;
         rem_q      <= '0;
         left_q     <= '0;
      end else if (load) begin
         beat_out   <= load_word[DATA_W-1:0];
         beat_valid <= 1'b1;
         rem_q      <= load_word[WORD_W-1:DATA_W];
         left_q     <= LAST_BEAT;
      end else if (left_q != '0) begin
         beat_out   <= rem_q[DATA_W-1:0];
         beat_valid <= 1'b1;
         rem_q      <= rem_q >> DATA_W;
         left_q     <= left_q - ONE_BEAT;
      end else begin
         beat_out   <= '0;
         beat_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/bmem_b4_core.sv
module bmem_b4_core
   import bmem_pkg::*;
#(
   parameter int DATA_W   = 18,
   parameter int ADDR_W   = 6,
   parameter int READ_LAT = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              conflict_err
);
   localparam int WORD_W = DATA_W * BEATS;

   if (DATA_W < 1) begin : g_bad_width
      $error("bmem_b4_core: DATA_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("bmem_b4_core: ADDR_W must lie in 1..12");
   end
   if (READ_LAT < 1 || READ_LAT > 8) begin : g_bad_lat
      $error("bmem_b4_core: READ_LAT must lie in 1..8");
   end

   logic              rd_issue;
   logic              wr_issue;
   logic              wr_busy;
   logic              commit;
   logic [ADDR_W-1:0] commit_addr;
   logic [WORD_W-1:0] commit_word;
   logic [WORD_W-1:0] array_word;

   bmem_cmd_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_req       (rd_req),
      .wr_req       (wr_req),
      .wr_busy      (wr_busy),
      .rd_issue     (rd_issue),
      .wr_issue     (wr_issue),
      .conflict_err (conflict_err)
   );

   bmem_wr_collect #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_collect (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (wr_issue),
      .addr_in     (addr),
      .beat_in     (wr_data),
      .busy        (wr_busy),
      .commit      (commit),
      .commit_addr (commit_addr),
      .commit_word (commit_word)
   );

   bmem_array #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W)
   ) u_array (
      .clk   (clk),
      .we    (commit),
      .waddr (commit_addr),
      .wdata (commit_word),
      .re    (rd_issue),
      .raddr (addr),
      .rdata (array_word)
   );

   bmem_rd_serial #(
      .DATA_W   (DATA_W),
      .READ_LAT (READ_LAT)
   ) u_serial (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (rd_issue),
      .word_in    (array_word),
      .beat_out   (rd_data),
      .beat_valid (rd_valid)
   );
endmodule

// File: rtl/bmem_b4_core_chk.sv
module bmem_b4_core_chk #(
   parameter int DATA_W   = 18,
   parameter int READ_LAT = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic              wr_req,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid,
   input logic              conflict_err
);
   logic [1:0]          gap_q;
   logic                taken;
   logic [READ_LAT-1:0] lat_q;
   logic [2:0]          owed_q;

   assign taken = rd_req && (gap_q == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= 2'd0;
         lat_q  <= '0;
         owed_q <= 3'd0;
      end else begin
         if (taken) begin
            gap_q <= 2'd3;
         end else if (gap_q != 2'd0) begin
            gap_q <= gap_q - 2'd1;
         end
         lat_q[0] <= taken;
         for (int i = 1; i < READ_LAT; i++) begin
            lat_q[i] <= lat_q[i-1];
         end
         if (lat_q[READ_LAT-1]) begin
            owed_q <= 3'd4;
         end else if (owed_q != 3'd0) begin
            owed_q <= owed_q - 3'd1;
         end
      end
   end

   AST_VALID_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == (owed_q != 3'd0)); // R4

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      lat_q[READ_LAT-1] |=> rd_valid); // R3

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0)); // R5

   AST_CONFLICT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && wr_req) |=> conflict_err); // R8

   AST_CONFLICT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req) |=> !conflict_err); // R8
endmodule

bind bmem_b4_core bmem_b4_core_chk #(
   .DATA_W   (DATA_W),
   .READ_LAT (READ_LAT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_req       (rd_req),
   .wr_req       (wr_req),
   .rd_data      (rd_data),
   .rd_valid     (rd_valid),
   .conflict_err (conflict_err)
);

// File: tb/bmem_b4_core_bench.sv
module bmem_b4_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 18;
   localparam int AW  = 6;
   localparam int LAT = 3;
   localparam int NB  = 4;
   localparam int NG  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_req = 1'b0;
   logic          wr_req = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic          conflict_err;

   bmem_b4_core #(.DATA_W(DW), .ADDR_W(AW), .READ_LAT(LAT)) u_bmem_b4_core (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
      .rd_valid(rd_valid), .conflict_err(conflict_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic [DW-1:0] data;
      int            due;
      string         tag;
   } exp_t;

   exp_t          sb[$];
   logic [DW-1:0] model [NG][NB];
   int            cyc = 0;
   int            checks = 0;
   int            errors = 0;
   bit            done = 1'b0;
   logic          conf_exp = 1'b0;

   always @(posedge clk) begin
      cyc      <= cyc + 1;
      conf_exp <= rst_n && rd_req && wr_req;
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mk(input int a, input int k, input int salt);
      return DW'(a * 37 + k * 5 + salt * 1031 + 3);
   endfunction

   // Monitor: compares read beats against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(conflict_err == conf_exp, "R8", "conflict flag",
               32'(conflict_err), 32'(conf_exp));
         if (rd_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R4", "valid beat with nothing pending", 32'(rd_data), 32'hx);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(rd_data == e.data, e.tag, "read beat data", 32'(rd_data), 32'(e.data));
               check(cyc == e.due, "R4", "beat cycle", 32'(cyc), 32'(e.due));
            end
         end else begin
            check(rd_data == '0, "R5", "idle read bus", 32'(rd_data), 32'h0);
            if (sb.size() != 0 && sb[0].due <= cyc) begin
               exp_t e;
               e = sb.pop_front();
               check(1'b0, "R4", "missing beat", 32'(rd_valid), 32'h1);
            end
         end
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_read(input int a, input string tag);
      for (int k = 0; k < NB; k++) begin
         exp_t e;
         e.data = model[a][k];
         e.due  = cyc + LAT + 1 + k;
         e.tag  = tag;
         sb.push_back(e);
      end
   endtask

   task automatic start_read(input int a, input string tag);
      rd_req = 1'b1;
      addr   = AW'(a);
      push_read(a, tag);
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   // intr < 0: plain write; otherwise a second wr_req at beat 1 with that address
   task automatic do_write(input int a, input int salt, input int intr);
      logic [DW-1:0] b [NB];
      for (int k = 0; k < NB; k++) b[k] = mk(a, k, salt);
      wr_req  = 1'b1;
      addr    = AW'(a);
      wr_data = b[0];
      for (int k = 1; k < NB; k++) begin
         @(negedge clk);
         wr_req  = (k == 1 && intr >= 0);
         if (k == 1 && intr >= 0) addr = AW'(intr);
         wr_data = b[k];
      end
      @(negedge clk);
      wr_req = 1'b0;
      model[a] = b;
   endtask

   initial begin : main
      wait_cyc(3);
      check(rd_valid == 1'b0, "R1", "valid in reset", 32'(rd_valid), 32'h0);
      check(rd_data == '0, "R1", "data in reset", 32'(rd_data), 32'h0);
      check(conflict_err == 1'b0, "R1", "error in reset", 32'(conflict_err), 32'h0);
      rst_n = 1'b1;
      wait_cyc(4);
      check(rd_valid == 1'b0 && rd_data == '0, "R1", "quiet before first read",
            32'(rd_valid), 32'h0);

      // R2 R6: fill every group
      for (int a = 0; a < NG; a++) do_write(a, 0, -1);

      // R3 R4 R6: reads four cycles apart, lowest and highest group
      start_read(0, "R6");
      wait_cyc(3);
      start_read(NG - 1, "R6");
      wait_cyc(3);
      start_read(5, "R3");
      wait_cyc(10);

      // R2: overwrite then read
      do_write(9, 1, -1);
      start_read(9, "R2");
      wait_cyc(8);

      // R7: read on the commit edge, then on the second beat
      fork
         do_write(12, 2, -1);
         begin wait_cyc(3); start_read(12, "R7"); end
      join
      wait_cyc(4);
      start_read(12, "R2");
      wait_cyc(8);
      fork
         do_write(14, 3, -1);
         begin wait_cyc(1); start_read(14, "R7"); end
      join
      wait_cyc(8);
      start_read(14, "R2");
      wait_cyc(8);

      // R8: both commands in one cycle
      rd_req  = 1'b1;
      wr_req  = 1'b1;
      addr    = AW'(17);
      wr_data = ~mk(17, 0, 0);
      push_read(17, "R8");
      @(negedge clk);
      rd_req = 1'b0;
      wr_req = 1'b0;
      check(conflict_err == 1'b1, "R8", "flag after conflict", 32'(conflict_err), 32'h1);
      for (int k = 1; k < NB; k++) begin
         wr_data = ~mk(17, k, 0);
         @(negedge clk);
      end
      check(conflict_err == 1'b0, "R8", "flag clears", 32'(conflict_err), 32'h0);
      wait_cyc(6);
      start_read(17, "R8");
      wait_cyc(8);

      // R9: second write inside an open burst
      do_write(20, 4, 21);
      wait_cyc(1);
      start_read(21, "R9");
      wait_cyc(3);
      start_read(20, "R9");
      wait_cyc(8);

      // R10: read request inside the read gap
      start_read(30, "R10");
      wait_cyc(1);
      rd_req = 1'b1;
      addr   = AW'(31);
      @(negedge clk);
      rd_req = 1'b0;
      wait_cyc(12);
      check(rd_valid == 1'b0, "R10", "no extra beats", 32'(rd_valid), 32'h0);
      check(sb.size() == 0, "R4", "all beats delivered", 32'(sb.size()), 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         check(1'b0, "R4", "watchdog expired", 32'h0, 32'h1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule